// File: doc/BRIEF.md
# Line-Buffer Vertical FIR Convolver

This block filters a raster-scan pixel stream along image columns with a programmable TAPS-tap coefficient set. It keeps only TAPS-1 earlier lines in on-chip line memories and never holds a whole frame. Its input is the narrowed stream from a horizontal filter stage. Image width and height are runtime inputs. The block processes `img_width_i - (TAPS-1)` samples per line.

Each accepted sample is used directly as the newest tap. In the same pass it is written into the line memories, and every stored line moves one memory older at that column. Once TAPS-1 lines of the frame are stored, the block emits one filtered pixel for every accepted sample, at a rate of one pixel per clock. A valid/ready handshake on each side carries backpressure. A start-of-frame pulse realigns the scan counters. Coefficients are loaded one slot at a time through a small write port.

Top module: `vconv_line_fir`

## Requirements
- R1: The processed line length is L = img_width_i - (TAPS-1). The column index runs 0..L-1, and the line index advances after column L-1.
- R2: For a sample at line r and column c, the output is the unsigned full-precision sum of coef[i] * sample(line r-(TAPS-1)+i, column c) for i = 0..TAPS-1. Coefficient slot 0 weights the oldest line and slot TAPS-1 weights the current sample. Each pixel's sum starts from zero.
- R3: Samples on lines 0..TAPS-2 of a frame produce no output. Every sample on line TAPS-1 or later produces exactly one output, in raster order.
- R4: With no stall, an emitting sample accepted in cycle n appears on out_valid_o/out_data_o after the second rising edge that follows.
- R5: While out_valid_o is high and out_ready_i is low, in_ready_o is low, out_data_o holds, and the counters and line memories stay frozen. Stalls and input gaps leave the output stream unchanged.
- R6: A sof_i pulse resets the line and column counters to zero. A sample accepted with sof_i high counts as line 0, column 0. A partly sent earlier frame has no effect on the outputs of the new frame.
- R7: After column L-1 of line img_height_i-1, both counters return to zero, so the next frame needs no sof_i.
- R8: The line memories are never cleared. The outputs of a frame do not depend on the contents left by an earlier frame.
- R9: With L = 1, a sample reads the same column that the previous sample writes in that cycle, and it sees the updated value. Results still follow R2.
- R10: When coef_we_i is high, coef_i is written into slot coef_sel_i. Samples accepted from that edge onward use the new value.
- R11: After reset, out_valid_o is 0, in_ready_o is 1, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| img_width_i | input | COL_W | Image width before the horizontal border loss |
| img_height_i | input | ROW_W | Lines per frame |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | SEL_W | Coefficient slot to write |
| coef_i | input | COEF_W | Coefficient value |
| sof_i | input | 1 | Start-of-frame pulse |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| in_data_i | input | DATA_W | Input sample |
| out_valid_o | output | 1 | Filtered pixel valid |
| out_ready_i | input | 1 | Downstream accepts the pixel |
| out_data_o | output | ACC_W | Filtered pixel |

## Verification
The main function runs through a table of frames that differ in width, height and coefficients. The table includes:
- A plain unstalled frame, which pins the column weighting and the latency.
- A three-pixel-wide frame, whose single column exposes the same-address read/write case.
- A maximum-width frame with all-ones coefficients and near-full pixels, which checks the accumulator width.
- A frame exactly TAPS lines tall.
- Frames with random-looking output stalls and input gaps.

Some frames follow the previous one without a start pulse. Comparing them shows whether the counters wrap correctly and whether stale line-memory data leaks into the new frame. A directed test aborts a frame partway through a line and restarts it with sof_i. Misaligned outputs in that test show whether the pulse realigns the counters.

// File: rtl/vconv_pkg.sv
package vconv_pkg;
  function automatic int acc_width(int dw, int cw, int taps);
    return dw + cw + ((taps > 1) ? $clog2(taps) : 0);
  endfunction
endpackage

// File: rtl/vconv_line_ram.sv
module vconv_line_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 14,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // write-first: a read colliding with the write returns the new word
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_q <= (wr_en_i && (wr_addr_i == rd_addr_i)) ? wr_data_i : mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/vconv_coef_bank.sv
module vconv_coef_bank #(
  parameter int TAPS   = 3,
  parameter int COEF_W = 8,
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [COEF_W-1:0]            data_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coefs_o
);
  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              coefs_o[g] <= '0;
      else if (we_i && (sel_i == SEL_W'(g)))    coefs_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/vconv_scan_ctrl.sv
module vconv_scan_ctrl #(
  parameter int TAPS  = 3,
  parameter int COL_W = 5,
  parameter int ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             fire_i,
  input  logic [COL_W-1:0] line_len_i,
  input  logic [ROW_W-1:0] height_i,
  output logic [COL_W-1:0] eff_col_o,
  output logic             emit_o,
  output logic [COL_W-1:0] col_q_o,
  output logic [ROW_W-1:0] line_q_o
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] line_q;
  logic [ROW_W-1:0] eff_line;
  logic             last_col, last_line;

  assign eff_col_o = sof_i ? '0 : col_q;
  assign eff_line  = sof_i ? '0 : line_q;
  assign last_col  = (eff_col_o == line_len_i - COL_W'(1));
  assign last_line = (eff_line == height_i - ROW_W'(1));
  assign emit_o    = (eff_line >= ROW_W'(TAPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (fire_i) begin
      col_q  <= last_col ? '0 : eff_col_o + COL_W'(1);
      line_q <= !last_col ? eff_line : (last_line ? '0 : eff_line + ROW_W'(1));
    end else if (sof_i) begin
      col_q  <= '0;
      line_q <= '0;
    end
  end

  assign col_q_o  = col_q;
  assign line_q_o = line_q;
endmodule

// File: rtl/vconv_mac.sv
module vconv_mac #(
  parameter int TAPS   = 3,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        load_i,
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  input  logic [TAPS-1:0][COEF_W-1:0] coefs_i,
  output logic                        out_valid_o,
  output logic [ACC_W-1:0]            out_data_o
);
  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + ACC_W'(taps_i[i]) * ACC_W'(coefs_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (en_i) begin
      out_valid_o <= load_i;
      if (load_i) out_data_o <= acc;
    end
  end
endmodule

// File: rtl/vconv_line_fir.sv
module vconv_line_fir #(
  parameter int TAPS       = 3,
  parameter int DATA_W     = 8,
  parameter int COEF_W     = 8,
  parameter int MAX_WIDTH  = 16,
  parameter int MAX_HEIGHT = 64,
  localparam int COL_W = $clog2(MAX_WIDTH + 1),
  localparam int ROW_W = $clog2(MAX_HEIGHT + 1),
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ACC_W = vconv_pkg::acc_width(DATA_W, COEF_W, TAPS),
  localparam int DEPTH = MAX_WIDTH - (TAPS - 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COL_W-1:0]  img_width_i,
  input  logic [ROW_W-1:0]  img_height_i,
  input  logic              coef_we_i,
  input  logic [SEL_W-1:0]  coef_sel_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              sof_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ACC_W-1:0]  out_data_o
);
  logic                        en, fire, emit_ok;
  logic [COL_W-1:0]            line_len, eff_col, ctrl_col;
  logic [ROW_W-1:0]            ctrl_line;
  logic                        s1_valid, s1_emit;
  logic [DATA_W-1:0]           s1_data;
  logic [AW-1:0]               s1_addr;
  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic [TAPS-1:0][COEF_W-1:0] coefs;

  assign line_len   = img_width_i - COL_W'(TAPS - 1);
  assign en         = !(out_valid_o && !out_ready_i);
  assign in_ready_o = en;
  assign fire       = in_valid_i && en;

  vconv_scan_ctrl #(.TAPS(TAPS), .COL_W(COL_W), .ROW_W(ROW_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .fire_i     (fire),
    .line_len_i (line_len),
    .height_i   (img_height_i),
    .eff_col_o  (eff_col),
    .emit_o     (emit_ok),
    .col_q_o    (ctrl_col),
    .line_q_o   (ctrl_line)
  );

  vconv_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (coef_we_i),
    .sel_i   (coef_sel_i),
    .data_i  (coef_i),
    .coefs_o (coefs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_emit  <= 1'b0;
      s1_data  <= '0;
      s1_addr  <= '0;
    end else if (en) begin
      s1_valid <= fire;
      s1_emit  <= fire && emit_ok;
      if (fire) begin
        s1_data <= in_data_i;
        s1_addr <= eff_col[AW-1:0];
      end
    end
  end

  // memory g holds the line TAPS-1-g lines above the current one
  for (genvar g = 0; g < TAPS - 1; g++) begin : g_line
    vconv_line_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk_i     (clk_i),
      .rd_en_i   (fire),
      .rd_addr_i (eff_col[AW-1:0]),
      .wr_en_i   (en && s1_valid),
      .wr_addr_i (s1_addr),
      .wr_data_i (taps[g+1]),
      .rd_data_o (taps[g])
    );
  end
  assign taps[TAPS-1] = s1_data;

  vconv_mac #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .load_i      (s1_valid && s1_emit),
    .taps_i      (taps),
    .coefs_i     (coefs),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/vconv_line_fir_chk.sv
module vconv_line_fir_chk #(
  parameter int TAPS  = 3,
  parameter int COL_W = 5,
  parameter int ROW_W = 7,
  parameter int ACC_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [ACC_W-1:0] out_data_o,
  input logic [COL_W-1:0] col_q,
  input logic [ROW_W-1:0] line_q,
  input logic             emit_ok,
  input logic [COL_W-1:0] line_len
);
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_ready_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o && !sof_i |=> $stable(col_q) && $stable(line_q));

  assert_emit_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && emit_ok) ##1 in_ready_o |=> out_valid_o);

  assert_no_early_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !emit_ok) ##1 in_ready_o |=> !out_valid_o);

  assert_sof_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && !in_valid_i |=> (col_q == '0) && (line_q == '0));

  assert_col_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q < line_len);
endmodule

bind vconv_line_fir vconv_line_fir_chk #(
  .TAPS(TAPS), .COL_W(COL_W), .ROW_W(ROW_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .col_q       (ctrl_col),
  .line_q      (ctrl_line),
  .emit_ok     (emit_ok),
  .line_len    (line_len)
);

// File: tb/vconv_line_fir_test.sv
`timescale 1ns/1ps
module vconv_line_fir_test;
  localparam int K     = 3;
  localparam int DW    = 8;
  localparam int CW    = 8;
  localparam int COLW  = 5;
  localparam int ROWW  = 7;
  localparam int ACCW  = 18;
  localparam int N_CFG = 5;
  // width, height, c0, c1, c2, stall, gaps, sof
  localparam int CFG [N_CFG][8] = '{
    '{ 8, 5,   1,   2,   1, 0, 0, 1},
    '{ 3, 4,   3,   0,   5, 0, 0, 0},
    '{16, 6, 255, 255, 255, 1, 0, 1},
    '{10, 3,   0,   1,   0, 0, 1, 0},
    '{ 6, 7,   7,   1,   2, 1, 1, 1}
  };

  logic clk = 0, rst_ni = 0;
  logic [COLW-1:0] img_width = 5'd8;
  logic [ROWW-1:0] img_height = 7'd5;
  logic coef_we = 0, sof = 0, in_valid = 0, out_ready = 1;
  logic [1:0] coef_sel = 0;
  logic [CW-1:0] coef = 0;
  logic [DW-1:0] in_data = 0;
  logic in_ready_o, out_valid_o;
  logic [ACCW-1:0] out_data_o;

  int checks = 0, fails = 0, cyc = 0, stall_mode = 0;
  int got_total = 0, acc_total = 0;
  int lat_acc_idx = -1, lat_out_idx = -1, acc_cyc = 0, out_cyc = 0;
  logic [ACCW-1:0] got [0:1023];
  bit prev_stall = 0, done = 0;
  logic [ACCW-1:0] prev_data = 0;

  vconv_line_fir uut (
    .clk_i(clk), .rst_ni(rst_ni), .img_width_i(img_width), .img_height_i(img_height),
    .coef_we_i(coef_we), .coef_sel_i(coef_sel), .coef_i(coef), .sof_i(sof),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_data_o(out_data_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    out_ready = (stall_mode == 0) || !((cyc % 5 == 1) || (cyc % 7 == 3));
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_stall) begin
        check(out_valid_o && out_data_o == prev_data, "R5 stall hold", out_data_o, prev_data);
        check(!(out_valid_o && !out_ready) || !in_ready_o, "R5 ready low", in_ready_o, 0);
      end
      prev_stall = out_valid_o && !out_ready;
      prev_data  = out_data_o;
      if (out_valid_o && out_ready) begin
        got[got_total % 1024] = out_data_o;
        got_total++;
        if (got_total == lat_out_idx) out_cyc = cyc;
      end
      if (in_valid && in_ready_o) begin
        acc_total++;
        if (acc_total == lat_acc_idx) acc_cyc = cyc;
      end
    end
  end

  function automatic int pix(int f, int r, int c);
    if (f == 2) return 255 - ((r ^ c) & 3);
    return (f * 53 + r * 29 + c * 13 + r * c) % 256;
  endfunction

  task automatic send_px(input int d);
    in_valid = 1;
    in_data  = DW'(d);
    do @(negedge clk); while (!in_ready_o);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic load_coef(input int sel, input int val);
    coef_we = 1; coef_sel = 2'(sel); coef = CW'(val);
    @(posedge clk); #1;
    coef_we = 0;
  endtask

  task automatic pulse_sof();
    sof = 1;
    @(posedge clk); #1;
    sof = 0;
  endtask

  task automatic run_frame(input int f, input int w, input int h, input int c0, input int c1,
                           input int c2, input int sm, input int gm, input int use_sof,
                           input string tag, input bit lat);
    int l, base, n_exp, idx;
    longint e;
    l = w - (K - 1);
    img_width = COLW'(w);
    img_height = ROWW'(h);
    load_coef(0, c0); load_coef(1, c1); load_coef(2, c2);  // R10
    stall_mode = sm;
    if (use_sof != 0) pulse_sof();
    base  = got_total;
    n_exp = (h - (K - 1)) * l;
    if (lat) begin
      lat_acc_idx = acc_total + (K - 1) * l + 1;
      lat_out_idx = base + 1;
    end
    for (int r = 0; r < h; r++)
      for (int c = 0; c < l; c++) begin
        send_px(pix(f, r, c));
        if (gm != 0 && ((r + c) % 3 == 2)) begin @(posedge clk); #1; end
      end
    for (int t = 0; t < 600 && (got_total - base) < n_exp; t++) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
    stall_mode = 0;
    check(got_total - base == n_exp, {tag, " R3 count"}, got_total - base, n_exp);
    for (int r = K - 1; r < h; r++)
      for (int c = 0; c < l; c++) begin
        idx = base + (r - (K - 1)) * l + c;
        e = longint'(c0) * pix(f, r - 2, c) + longint'(c1) * pix(f, r - 1, c) + longint'(c2) * pix(f, r, c);
        if (idx < got_total) check(got[idx % 1024] == ACCW'(e), {tag, " R2 value"}, got[idx % 1024], e);
      end
    if (lat) begin
      check(out_cyc - acc_cyc == 2, "R4 latency", out_cyc - acc_cyc, 2);
      lat_acc_idx = -1;
      lat_out_idx = -1;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    check(out_valid_o == 0, "R11 out_valid after reset", out_valid_o, 0);
    check(in_ready_o == 1, "R11 in_ready after reset", in_ready_o, 1);
    @(posedge clk); #1;

    // table walk; frames 1 and 3 follow without sof (R7, R8); frame 1 has L=1 (R9)
    for (int i = 0; i < N_CFG; i++)
      run_frame(i, CFG[i][0], CFG[i][1], CFG[i][2], CFG[i][3], CFG[i][4],
                CFG[i][5], CFG[i][6], CFG[i][7],
                (i == 1) ? "R1 R7 R8 R9" : "R1 R2", i == 0);

    // R6: abort a frame mid-line, restart with sof
    img_width = 5'd8;
    img_height = 7'd4;
    pulse_sof();
    for (int c = 0; c < 8; c++) send_px(pix(9, c / 6, c % 6));
    run_frame(5, 8, 4, 2, 3, 4, 0, 0, 1, "R6 restart", 0);

    // R7: back-to-back frame without sof after the restart
    run_frame(6, 8, 4, 1, 1, 1, 1, 0, 0, "R7 wrap", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule